// File: doc/BRIEF.md
# Credit-Gated Virtual Output Queue Scheduler

This block sits on the ingress side of a switch fabric built around a crossbar with a small buffer at every crosspoint. Fixed-size cells arrive one at a time, each tagged with the output it is bound for. They are sorted into one private queue per output, so a cell waiting for a busy output never holds up cells bound elsewhere. In every clock cycle (one time slot) the block chooses at most one queue in round-robin order and launches that queue's head cell into the crossbar, tagged with its destination.

A queue may compete only while it holds a cell and the crosspoint buffer it feeds still has room. The scheduler tracks that room with one credit counter per output. The counter starts at the buffer capacity, drops by one for every cell launched and rises by one for every pulse on the credit-return vector sent back by the crossbar. When a queue is full, an arrival for it is refused and the refusal is flagged in the same cycle.

A two-state slot machine drives the launch output. The state SLOT_IDLE means no cell was launched in the slot just decided. The state SLOT_LAUNCH means one was. From either state the machine moves to SLOT_LAUNCH when at least one queue is eligible at the clock edge, and to SLOT_IDLE when none is.

Top module: `voq_credit_sched`

## Requirements
- R1: An arrival (`arr_valid` high) is written into the queue named by `arr_dest` unless that queue already holds `Q_DEPTH` cells at the start of the cycle. In that case `arr_stall` is high in the same cycle, combinationally, and the cell is discarded. `arr_stall` is low whenever `arr_valid` is low.
- R2: Cells bound for one destination leave the block in the order in which they were accepted.
- R3: A queue is eligible only when it is non-empty and its credit counter is non-zero, both taken from registered state at the clock edge. A cell accepted at edge t can therefore be launched no earlier than edge t+1.
- R4: At most one cell is launched per slot. A launch decided at edge t shows on `xb_valid`/`xb_dest`/`xb_data` from edge t until edge t+1. `xb_valid` is low after any edge at which no queue was eligible.
- R5: The round-robin search starts at the pointer queue and goes through increasing indices, wrapping from N_OUT-1 to 0. After a launch from queue j the pointer becomes (j+1) mod N_OUT. After a slot with no launch the pointer is unchanged.
- R6: Each credit counter starts at `XP_CREDITS`. It falls by one per launch to its destination and rises by one per high bit `credit_ret[j]`. A return and a launch for the same destination in one slot leave the counter unchanged. A returned credit first counts at the following edge.
- R7: Reset (`rst_n` low, synchronous) empties every queue, sets every counter to `XP_CREDITS`, sets the pointer to queue 0 and drives `xb_valid` low.
- R8: A queue blocked by zero credit does not stop an eligible queue of another destination from being launched in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | 1 | An arriving cell is present |
| arr_dest | input | $clog2(N_OUT) | Output index of the arriving cell |
| arr_data | input | CELL_W | Payload of the arriving cell |
| arr_stall | output | 1 | Arrival refused because its queue is full |
| xb_valid | output | 1 | A cell is being launched into the crossbar |
| xb_dest | output | $clog2(N_OUT) | Output index of the launched cell |
| xb_data | output | CELL_W | Payload of the launched cell |
| credit_ret | input | N_OUT | One-cycle credit return pulse per output |

## Verification
The bench builds the block with four outputs, a queue depth of four, two credits per crosspoint and eight-bit cells. With only two credits, a few launches empty a counter, so credit starvation, same-slot return and consume, and late returns all come up within a short run. A depth of four makes it possible to fill a queue and hit the refusal path while that queue is starved. Four outputs keep the pointer wrap and the choice between several eligible queues easy to follow cell by cell.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;

    // Launch state of the slot that was just decided
    typedef enum logic [0:0] {
        SLOT_IDLE   = 1'b0,
        SLOT_LAUNCH = 1'b1
    } slot_state_e;

endpackage

// File: rtl/voq_cell_fifo.sv
module voq_cell_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

    // R1: the caller never writes into a full queue
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R2: the scheduler never takes a cell from an empty queue
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/voq_credit_ctr.sv
module voq_credit_ctr #(
    parameter int CREDITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret,
    input  logic take,
    output logic avail
);
    localparam int CW = $clog2(CREDITS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(CREDITS);
        end else begin
            unique case ({ret, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        avail = (cnt != '0);
    end

    // R6: a launch is only made against a held credit
    a_r6_take_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt != '0);

    // R6: a lone return never lifts the counter past the buffer size
    a_r6_no_excess_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |-> cnt < CW'(CREDITS));

    // R6: return and consume in one slot cancel out
    a_r6_paired_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && take) |=> $stable(cnt));

endmodule

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] ptr,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] gidx,
    output logic                 found
);
    localparam int IW = $clog2(N);

    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int s;
            s = int'(ptr) + i;
            if (s >= N) begin
                s = s - N;
            end
            if (!found && req[s]) begin
                found    = 1'b1;
                gidx     = IW'(s);
                grant[s] = 1'b1;
            end
        end
    end

    // R4: one queue at most wins a slot
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: only an eligible queue can win
    a_r3_grant_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R5: some eligible queue always wins when any exists
    a_r5_no_idle_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> $countones(grant) == 1);

endmodule

// File: rtl/voq_credit_sched.sv
module voq_credit_sched
    import voq_sched_pkg::*;
#(
    parameter int N_OUT      = 4,
    parameter int Q_DEPTH    = 4,
    parameter int XP_CREDITS = 2,
    parameter int CELL_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arr_valid,
    input  logic [$clog2(N_OUT)-1:0] arr_dest,
    input  logic [CELL_W-1:0]        arr_data,
    output logic                     arr_stall,
    output logic                     xb_valid,
    output logic [$clog2(N_OUT)-1:0] xb_dest,
    output logic [CELL_W-1:0]        xb_data,
    input  logic [N_OUT-1:0]         credit_ret
);
    localparam int IW = $clog2(N_OUT);

    logic [N_OUT-1:0]  q_push;
    logic [N_OUT-1:0]  q_empty;
    logic [N_OUT-1:0]  q_full;
    logic [N_OUT-1:0]  cr_avail;
    logic [N_OUT-1:0]  eligible;
    logic [N_OUT-1:0]  grant;
    logic [CELL_W-1:0] q_head [N_OUT];
    logic [IW-1:0]     gidx;
    logic              any_pick;
    logic [IW-1:0]     ptr_q;
    logic [IW-1:0]     xb_dest_q;
    logic [CELL_W-1:0] xb_data_q;
    slot_state_e       state_q;
    slot_state_e       state_d;

    // Per-destination queues and credit counters
    for (genvar j = 0; j < N_OUT; j++) begin : g_dest
        always_comb begin
            q_push[j]   = arr_valid && (arr_dest == IW'(j)) && !q_full[j];
            eligible[j] = !q_empty[j] && cr_avail[j];
        end

        voq_cell_fifo #(
            .DEPTH (Q_DEPTH),
            .WIDTH (CELL_W)
        ) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[j]),
            .din   (arr_data),
            .pop   (grant[j]),
            .head  (q_head[j]),
            .empty (q_empty[j]),
            .full  (q_full[j])
        );

        voq_credit_ctr #(
            .CREDITS (XP_CREDITS)
        ) u_credit (
            .clk   (clk),
            .rst_n (rst_n),
            .ret   (credit_ret[j]),
            .take  (grant[j]),
            .avail (cr_avail[j])
        );
    end

    always_comb begin
        arr_stall = arr_valid && q_full[arr_dest];
    end

    voq_rr_pick #(
        .N (N_OUT)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (eligible),
        .ptr   (ptr_q),
        .grant (grant),
        .gidx  (gidx),
        .found (any_pick)
    );

    // Round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (any_pick) begin
            ptr_q <= (gidx == IW'(N_OUT - 1)) ? '0 : gidx + 1'b1;
        end
    end

    // Slot state: next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:   state_d = any_pick ? SLOT_LAUNCH : SLOT_IDLE;
            SLOT_LAUNCH: state_d = any_pick ? SLOT_LAUNCH : SLOT_IDLE;
            default:     state_d = SLOT_IDLE;
        endcase
    end

    // Slot state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Launched cell holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xb_dest_q <= '0;
            xb_data_q <= '0;
        end else if (any_pick) begin
            xb_dest_q <= gidx;
            xb_data_q <= q_head[gidx];
        end
    end

    // Outputs
    always_comb begin
        xb_valid = (state_q == SLOT_LAUNCH);
        xb_dest  = xb_dest_q;
        xb_data  = xb_data_q;
    end

    // R4: a slot with a winner launches in the next cycle
    a_r4_launch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        any_pick |=> xb_valid);

    // R4: a slot without a winner leaves the crossbar idle
    a_r4_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pick |=> !xb_valid);

    // R5: pointer holds when nothing was sent
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pick |=> $stable(ptr_q));

    // R1: a refused arrival writes no queue
    a_r1_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_stall |-> q_push == '0);

endmodule

// File: tb/voq_credit_sched_tb_top.sv
module voq_credit_sched_tb_top;

    localparam int N_OUT = 4;
    localparam int QD    = 4;
    localparam int KCR   = 2;
    localparam int CW    = 8;
    localparam int NVEC  = 25;

    typedef struct packed {
        logic       av;
        logic [1:0] ad;
        logic [7:0] adata;
        logic [3:0] cr;
        logic       x_stall;
        logic       x_v;
        logic [1:0] x_d;
        logic [7:0] x_data;
    } vec_t;

    // Fields: arrival valid/dest/data, credit returns, then expected stall,
    // expected launch valid/dest/data seen after the slot edge.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 8'h21, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 0  R3 not yet eligible
        '{1'b1, 2'd0, 8'h01, 4'b0000, 1'b0, 1'b1, 2'd2, 8'h21}, // 1  R4
        '{1'b1, 2'd2, 8'h22, 4'b0000, 1'b0, 1'b1, 2'd0, 8'h01}, // 2  R5 wrap 3->0
        '{1'b1, 2'd2, 8'h23, 4'b0000, 1'b0, 1'b1, 2'd2, 8'h22}, // 3  R6 credit 2 used
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 4  R3 no credit
        '{1'b0, 2'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 2'd0, 8'h00}, // 5  R6 return not yet usable
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b1, 2'd2, 8'h23}, // 6  R6
        '{1'b1, 2'd1, 8'h11, 4'b0100, 1'b0, 1'b0, 2'd0, 8'h00}, // 7
        '{1'b1, 2'd1, 8'h12, 4'b0010, 1'b0, 1'b1, 2'd1, 8'h11}, // 8  R6 paired
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b1, 2'd1, 8'h12}, // 9  R2
        '{1'b1, 2'd1, 8'h13, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 10
        '{1'b1, 2'd1, 8'h14, 4'b0000, 1'b0, 1'b1, 2'd1, 8'h13}, // 11 R6 last credit
        '{1'b1, 2'd1, 8'h15, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 12
        '{1'b1, 2'd1, 8'h16, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 13
        '{1'b1, 2'd1, 8'h17, 4'b0000, 1'b0, 1'b0, 2'd0, 8'h00}, // 14 R1 fills
        '{1'b1, 2'd1, 8'h18, 4'b0000, 1'b1, 1'b0, 2'd0, 8'h00}, // 15 R1 refused
        '{1'b0, 2'd0, 8'h00, 4'b0010, 1'b0, 1'b0, 2'd0, 8'h00}, // 16
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b1, 2'd1, 8'h14}, // 17 R2
        '{1'b1, 2'd1, 8'h19, 4'b0010, 1'b0, 1'b0, 2'd0, 8'h00}, // 18 R1 space again
        '{1'b1, 2'd3, 8'h31, 4'b0000, 1'b0, 1'b1, 2'd1, 8'h15}, // 19
        '{1'b1, 2'd0, 8'h02, 4'b0000, 1'b0, 1'b1, 2'd3, 8'h31}, // 20 R8
        '{1'b1, 2'd2, 8'h24, 4'b0000, 1'b0, 1'b1, 2'd0, 8'h02}, // 21 R8
        '{1'b1, 2'd3, 8'h32, 4'b1011, 1'b0, 1'b1, 2'd2, 8'h24}, // 22 R8 q1 starved
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b1, 2'd3, 8'h32}, // 23 R5 ptr picks 3 over 1
        '{1'b0, 2'd0, 8'h00, 4'b0000, 1'b0, 1'b1, 2'd1, 8'h16}  // 24 R5 wrap to 1
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          arr_valid;
    logic [1:0]    arr_dest;
    logic [CW-1:0] arr_data;
    logic          arr_stall;
    logic          xb_valid;
    logic [1:0]    xb_dest;
    logic [CW-1:0] xb_data;
    logic [N_OUT-1:0] credit_ret;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;
    logic s_stall;

    always #4 clk = ~clk;

    voq_credit_sched #(
        .N_OUT      (N_OUT),
        .Q_DEPTH    (QD),
        .XP_CREDITS (KCR),
        .CELL_W     (CW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_valid  (arr_valid),
        .arr_dest   (arr_dest),
        .arr_data   (arr_data),
        .arr_stall  (arr_stall),
        .xb_valid   (xb_valid),
        .xb_dest    (xb_dest),
        .xb_data    (xb_data),
        .credit_ret (credit_ret)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One slot: drive at the falling edge, sample stall, then the launch
    task automatic slot(input logic av, input logic [1:0] ad, input logic [7:0] adat,
                        input logic [3:0] cr);
        @(negedge clk);
        arr_valid  = av;
        arr_dest   = ad;
        arr_data   = adat;
        credit_ret = cr;
        #1;
        s_stall = arr_stall;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic v, input logic [1:0] d,
                              input logic [7:0] dat);
        check({req, " valid"}, int'(xb_valid), int'(v));
        if (v) begin
            check({req, " dest"}, int'(xb_dest), int'(d));
            check({req, " data"}, int'(xb_data), int'(dat));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        arr_valid  = 1'b0;
        credit_ret = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R7 launch low in reset", int'(xb_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n      = 1'b0;
        arr_valid  = 1'b0;
        arr_dest   = '0;
        arr_data   = '0;
        credit_ret = '0;
        do_reset();

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            slot(VECS[i].av, VECS[i].ad, VECS[i].adata, VECS[i].cr);
            check($sformatf("R1 stall vec %0d", i), int'(s_stall), int'(VECS[i].x_stall));
            expect_out($sformatf("R4 vec %0d", i), VECS[i].x_v, VECS[i].x_d, VECS[i].x_data);
        end

        // R1/R2: refused 0x18 never appears; 17 is followed by 19
        slot(1'b0, 2'd0, 8'h00, 4'b0010); expect_out("R1 drop a", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R2 order 17", 1'b1, 2'd1, 8'h17);
        slot(1'b0, 2'd0, 8'h00, 4'b0010); expect_out("R1 drop b", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R1 refused cell skipped", 1'b1, 2'd1, 8'h19);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R2 queue drained", 1'b0, 2'd0, 8'h00);

        // R7: leave a cell starved in queue 1, then reset
        slot(1'b1, 2'd1, 8'h41, 4'b0000); expect_out("R7 pre", 1'b0, 2'd0, 8'h00);
        do_reset();
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R7 queue cleared a", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R7 queue cleared b", 1'b0, 2'd0, 8'h00);

        // R7/R6: credits back at two after reset
        slot(1'b1, 2'd0, 8'h51, 4'b0000); expect_out("R7 c0", 1'b0, 2'd0, 8'h00);
        slot(1'b1, 2'd0, 8'h52, 4'b0000); expect_out("R7 credit 1", 1'b1, 2'd0, 8'h51);
        slot(1'b1, 2'd0, 8'h53, 4'b0000); expect_out("R7 credit 2", 1'b1, 2'd0, 8'h52);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R6 exhausted a", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R6 exhausted b", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0001); expect_out("R6 return lag", 1'b0, 2'd0, 8'h00);
        slot(1'b0, 2'd0, 8'h00, 4'b0000); expect_out("R6 return used", 1'b1, 2'd0, 8'h53);
        check("R1 stall low when idle", int'(arr_stall), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

endmodule